// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits behind a simple register write/read port. Software programs a prescaler and a coarse reload value, enables the timer and then has to write a magic value to the restart register at regular intervals. A restart reloads the down-counter. If the counter is allowed to reach zero, the block sets a sticky status flag. It can also fire a single reset pulse of programmable length, raise an interrupt level, or do both.

Both control registers are protected against stray writes. A write is accepted only when a fixed key pattern sits in a reserved field of the written word. Any other write to that register is dropped whole. The restart register accepts only one exact 32-bit value. The fine part of the reload value is fixed at all ones over `LOW_BITS` bits, so each coarse unit stands for 2^`LOW_BITS` prescaled ticks.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode register (offset 0x0) reads 0, the count-control register (offset 0x4) reads 0x00003FFC (coarse value 0xFFF, prescaler code 0), the status register (offset 0xC) reads 0, and both `wdog_rst` and `wdog_irq` are low.
- R2: A write to offset 0x0 changes the mode fields only when written bits 23:12 equal 0xABC. The mode fields are: enable in bit 0, reset-output enable in bit 1, interrupt enable in bit 2, and pulse-length code in bits 5:4. A write with any other key leaves the register unchanged. Reads return only these fields.
- R3: A write to offset 0x4 changes the prescaler code (bits 1:0) and the coarse reload value (bits 13:2) only when written bits 25:14 equal 0x248. Otherwise the write is ignored. Reads return only these fields.
- R4: Writing exactly 0x00001999 to offset 0x8 loads the counter with {coarse value, `LOW_BITS` ones}, restarts the prescaler and clears the status flag. Any other value written there has no effect.
- R5: Prescaler codes 0, 1, 2 and 3 make the counter step down once every 8, 64, 512 and 4096 clock cycles.
- R6: With reload value N and division D, the status flag (status bit 0) reads 1 exactly N·D cycles after the clock edge that takes the restart write, and reads 0 one cycle earlier.
- R7: Once the counter reaches zero it stays at zero and the status flag stays set until the next valid restart. Each timeout triggers at most one reset pulse.
- R8: If reset-output enable is set at timeout, `wdog_rst` is high for 2, 4, 8 or 16 cycles for pulse codes 0 to 3. The pulse begins in the same cycle that the status flag becomes visible. With the enable clear, no pulse is produced.
- R9: `wdog_irq` is high whenever the status flag and interrupt enable are both set. It stays high after any reset pulse, until a valid restart.
- R10: While the enable bit is clear the counter holds its value and no timeout occurs. Counting resumes when the bit is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| wdog_rst | output | 1 | Timeout reset pulse |
| wdog_irq | output | 1 | Timeout interrupt level |

## Verification
The timeout path is exercised with one case per prescaler code, plus two larger coarse values at the fastest division. Together these separate a wrong division from a wrong reload concatenation. Each case samples the status flag one cycle before and exactly at the expected expiry, which exposes off-by-one errors in both the prescaler and the counter. The cases also rotate through all four pulse codes and every combination of reset enable and interrupt enable. This shows that the pulse length, the single pulse and the held interrupt each follow their own control bit. Directed cases cover:
- wrong keys on both control registers;
- a near-miss restart value;
- a restart in mid-count that must push expiry back;
- a pause through the enable bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CRV_W = 12;

  localparam logic [3:0] OFF_MODE    = 4'h0;
  localparam logic [3:0] OFF_CTRL    = 4'h4;
  localparam logic [3:0] OFF_RESTART = 4'h8;
  localparam logic [3:0] OFF_STATUS  = 4'hC;

  localparam logic [11:0] MODE_KEY    = 12'hABC;
  localparam logic [11:0] CTRL_KEY    = 12'h248;
  localparam logic [31:0] RESTART_VAL = 32'h0000_1999;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } mode_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             status_i,
  output mode_t            mode_o,
  output logic [CRV_W-1:0] crv_o,
  output logic [1:0]       psel_o,
  output logic             restart_o,
  output logic [31:0]      rdata
);
  mode_t            mode_q, mode_d;
  logic [CRV_W-1:0] crv_q, crv_d;
  logic [1:0]       psel_q, psel_d;
  logic             mode_wr, ctrl_wr;

  assign mode_wr   = wr_en && (addr == OFF_MODE) && (wdata[23:12] == MODE_KEY);
  assign ctrl_wr   = wr_en && (addr == OFF_CTRL) && (wdata[25:14] == CTRL_KEY);
  assign restart_o = wr_en && (addr == OFF_RESTART) && (wdata == RESTART_VAL);

  always_comb begin
    mode_d = mode_q;
    crv_d  = crv_q;
    psel_d = psel_q;
    if (mode_wr) begin
      mode_d.run    = wdata[0];
      mode_d.rst_en = wdata[1];
      mode_d.irq_en = wdata[2];
      mode_d.plen   = wdata[5:4];
    end
    if (ctrl_wr) begin
      psel_d = wdata[1:0];
      crv_d  = wdata[2 +: CRV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      crv_q  <= '1;
      psel_q <= 2'd0;
    end else begin
      mode_q <= mode_d;
      crv_q  <= crv_d;
      psel_q <= psel_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_MODE:   rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
      OFF_CTRL:   rdata = {{(30-CRV_W){1'b0}}, crv_q, psel_q};
      OFF_STATUS: rdata = {31'd0, status_i};
      default:    rdata = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign crv_o  = crv_q;
  assign psel_o = psel_q;

  p_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MODE && wdata[23:12] != MODE_KEY) |=> $stable(mode_o));
  p_ctrl_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CTRL && wdata[25:14] != CTRL_KEY) |=> ($stable(crv_o) && $stable(psel_o)));
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] psel_i,
  output logic       tick_o
);
  logic [11:0] pcnt_q, pcnt_d, last;

  always_comb begin
    case (psel_i)
      2'd0:    last = 12'd7;
      2'd1:    last = 12'd63;
      2'd2:    last = 12'd511;
      default: last = 12'd4095;
    endcase
  end

  assign tick_o = run_i && !clr_i && (pcnt_q == last);

  always_comb begin
    if (!run_i || clr_i || tick_o) pcnt_d = '0;
    else                           pcnt_d = pcnt_q + 12'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int LOW_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CRV_W-1:0] crv_i,
  output logic             fire_o,
  output logic             status_o
);
  localparam int CNT_W = CRV_W + LOW_BITS;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;

  assign fire_o = tick_i && !reload_i && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (reload_i) begin
      cnt_d  = {crv_i, {LOW_BITS{1'b1}}};
      stat_d = 1'b0;
    end else if (tick_i && cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (fire_o) stat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> !status_o);
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o && !reload_i) |=> status_o);
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload_i) |=> cnt_q == '0);
  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic       rst_en_i,
  input  logic [1:0] plen_i,
  output logic       pulse_o
);
  logic [4:0] left_q, left_d;

  always_comb begin
    if (fire_i && rst_en_i) left_d = 5'd2 << plen_i;
    else if (left_q != '0)  left_d = left_q - 5'd1;
    else                    left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse_o = (left_q != '0);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire_i && rst_en_i));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int LOW_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wdog_rst,
  output logic        wdog_irq
);
  logic [1:0]       rsync_q;
  logic             rst_s;
  mode_t            mode;
  logic [CRV_W-1:0] crv;
  logic [1:0]       psel;
  logic             restart, tick, fire, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .status_i(status), .mode_o(mode), .crv_o(crv), .psel_o(psel),
    .restart_o(restart), .rdata(rdata)
  );

  wdog_prescale u_pre (
    .clk(clk), .rst_n(rst_s), .run_i(mode.run), .clr_i(restart),
    .psel_i(psel), .tick_o(tick)
  );

  wdog_counter #(.LOW_BITS(LOW_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run_i(mode.run), .tick_i(tick),
    .reload_i(restart), .crv_i(crv), .fire_o(fire), .status_o(status)
  );

  wdog_pulse u_pulse (
    .clk(clk), .rst_n(rst_s), .fire_i(fire), .rst_en_i(mode.rst_en),
    .plen_i(mode.plen), .pulse_o(wdog_rst)
  );

  assign wdog_irq = status && mode.irq_en;

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (wdog_irq && !restart) |=> wdog_irq || !mode.irq_en);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdog_rst, wdog_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog #(.LOW_BITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wdog_rst(wdog_rst), .wdog_irq(wdog_irq)
  );

  typedef struct packed {
    logic [1:0]  pre;
    logic [11:0] crv;
    logic [1:0]  plen;
    logic        ren;
    logic        ien;
    int unsigned t_exp;
    int unsigned l_exp;
  } vec_t;

  // reload N = {crv, 4'hF}; expiry T = N * division; pulse L = 2 << plen when enabled
  localparam vec_t VECS [6] = '{
    '{2'd0, 12'd0, 2'd0, 1'b1, 1'b0, 120,   2},
    '{2'd1, 12'd0, 2'd1, 1'b0, 1'b1, 960,   0},
    '{2'd2, 12'd0, 2'd2, 1'b1, 1'b1, 7680,  8},
    '{2'd3, 12'd0, 2'd3, 1'b1, 1'b0, 61440, 16},
    '{2'd0, 12'd1, 2'd3, 1'b1, 1'b1, 248,   16},
    '{2'd0, 12'd2, 2'd1, 1'b0, 1'b0, 376,   0}
  };

  function automatic logic [31:0] mode_word(logic [11:0] key, logic run, logic ren,
                                            logic ien, logic [1:0] plen);
    return {8'h00, key, 6'd0, plen, 1'b0, ien, ren, run};
  endfunction

  function automatic logic [31:0] ctrl_word(logic [11:0] key, logic [11:0] crv, logic [1:0] pre);
    return {6'd0, key, crv, pre};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'hC; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 4'hC;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check("R1 mode", v, 32'h0);
    rd(4'h4, v); check("R1 ctrl", v, 32'h0000_3FFC);
    rd(4'hC, v); check("R1 status", v, 32'h0);
    check("R1 rst", {31'd0, wdog_rst}, 32'd0);
    check("R1 irq", {31'd0, wdog_irq}, 32'd0);

    // R2 mode key
    wr(4'h0, mode_word(12'hABD, 1'b1, 1'b1, 1'b1, 2'd3));
    rd(4'h0, v); check("R2 bad key ignored", v, 32'h0);
    wr(4'h0, mode_word(12'hABC, 1'b0, 1'b1, 1'b0, 2'd2));
    rd(4'h0, v); check("R2 good key", v, 32'h0000_0022);

    // R3 ctrl key
    wr(4'h4, ctrl_word(12'h249, 12'h123, 2'd2));
    rd(4'h4, v); check("R3 bad key ignored", v, 32'h0000_3FFC);
    wr(4'h4, ctrl_word(12'h248, 12'h123, 2'd2));
    rd(4'h4, v); check("R3 good key", v, {18'd0, 12'h123, 2'd2});

    // vector table: R5 R6 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      wr(4'h4, ctrl_word(12'h248, VECS[i].crv, VECS[i].pre));
      wr(4'h0, mode_word(12'hABC, 1'b1, VECS[i].ren, VECS[i].ien, VECS[i].plen));
      wr(4'h8, 32'h0000_1999);
      repeat (VECS[i].t_exp - 1) @(negedge clk);
      rd(4'hC, v); check("R5 R6 status before expiry", v, 32'd0);
      @(negedge clk);
      rd(4'hC, v); check("R5 R6 status at expiry", v, 32'd1);
      check("R9 irq at expiry", {31'd0, wdog_irq}, {31'd0, VECS[i].ien});
      hi = 0;
      for (int k = 0; k < 40; k++) begin
        if (wdog_rst) hi++;
        @(negedge clk);
      end
      check("R8 R7 pulse length", hi, VECS[i].l_exp);
      rd(4'hC, v); check("R7 status held", v, 32'd1);
      check("R9 irq held", {31'd0, wdog_irq}, {31'd0, VECS[i].ien});
    end

    // R4 restart value must be exact
    wr(4'h8, 32'h0000_1998);
    rd(4'hC, v); check("R4 bad restart ignored", v, 32'd1);
    wr(4'h8, 32'h0000_1999);
    rd(4'hC, v); check("R4 restart clears", v, 32'd0);

    // R4 mid-count restart postpones expiry
    wr(4'h4, ctrl_word(12'h248, 12'd0, 2'd0));
    wr(4'h0, mode_word(12'hABC, 1'b1, 1'b0, 1'b0, 2'd0));
    wr(4'h8, 32'h0000_1999);
    repeat (99) @(negedge clk);
    wr(4'h8, 32'h0000_1999);
    repeat (119) @(negedge clk);
    rd(4'hC, v); check("R4 reload postpones", v, 32'd0);
    @(negedge clk);
    rd(4'hC, v); check("R4 expiry after reload", v, 32'd1);

    // R10 halt while disabled
    wr(4'h8, 32'h0000_1999);
    repeat (40) @(negedge clk);
    wr(4'h0, mode_word(12'hABC, 1'b0, 1'b0, 1'b0, 2'd0));
    repeat (300) @(negedge clk);
    rd(4'hC, v); check("R10 no expiry while halted", v, 32'd0);
    wr(4'h0, mode_word(12'hABC, 1'b1, 1'b0, 1'b0, 2'd0));
    repeat (200) @(negedge clk);
    rd(4'hC, v); check("R10 resumes", v, 32'd1);

    finish_run();
  end
endmodule